// File: doc/BRIEF.md
# SPI Master with Slave-Ready Handshake

This block is a single-word SPI master. A host hands it one word through a valid/ready pair. The block lowers an active-low chip select and waits a programmable number of system-clock cycles. It then clocks the word out most significant bit first while it captures the word coming back from the slave. After a second programmable delay it raises chip select and returns the received word with a one-cycle done pulse. All four clock polarity/phase combinations are selectable. The serial clock runs at the system clock divided by an even divisor.

Two framing options extend the basic transfer. With the hold option set, if a new word is already offered when the last clock edge of a word is generated, chip select stays low and the next word follows without a deassertion. In five-pin mode the block also watches an active-low ready line from the slave. This line passes through a synchronizer first. No clocking begins while the line is inactive. After every word, the line must have gone inactive and then active again before the next word may start. When five-pin mode is off, the ready line is ignored. Configuration inputs are expected to stay constant while chip select is low.

Top module: `spi_hs_master`

## Requirements
- R1: After reset and between frames, `spi_cs_n` is 1, `rx_valid` is 0, `tx_ready` is 1 and `spi_sclk` rests at `cfg_cpol`.
- R2: Words move most significant bit first in both directions. With `cfg_cpha`=0 the master drives the MSB before the first edge and samples on odd edges (1st, 3rd, ...). With `cfg_cpha`=1 it drives on odd edges and samples on even edges. Counting starts at 1 in each word. The word sent by the host reaches the slave and the word sent by the slave appears on `rx_data`.
- R3: A word takes exactly 16 serial clock edges. Consecutive edges of a word are `max(cfg_half,1)` system cycles apart. No edge occurs while `spi_cs_n` is 1.
- R4: When five-pin mode is off, the first edge after a falling `spi_cs_n` comes exactly `cfg_setup + max(cfg_half,1) + 1` cycles later.
- R5: The last edge of a word returns `spi_sclk` to `cfg_cpol`. When the frame is not held, `spi_cs_n` rises exactly `cfg_trail + 1` cycles after that edge.
- R6: `rx_valid` is a single-cycle pulse carrying the received word. For a non-held frame it is high in the same cycle that `spi_cs_n` rises.
- R7: With `cfg_cs_hold`=1 and `tx_valid` high at the last edge, the next word is accepted in that cycle. `spi_cs_n` stays low across both words, and the first word's `rx_valid` pulse comes in the cycle after its last edge.
- R8: In five-pin mode, no clocking starts while the synchronized `spi_rdy_n` is 1. When `spi_rdy_n` falls after the setup delay has expired, the first edge comes `max(cfg_half,1) + 3` cycles after the cycle in which the change is presented.
- R9: In five-pin mode, once a word has finished, the next word does not start clocking until `spi_rdy_n` has been seen at 1 and then at 0 again.
- R10: With `cfg_five_pin`=0, a `spi_rdy_n` held at 1 has no effect on framing or data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| cfg_half | input | HALF_W | Half serial period in system cycles (0 acts as 1) |
| cfg_setup | input | SETUP_W | Extra cycles from chip select low to clocking |
| cfg_trail | input | TRAIL_W | Extra cycles from last edge to chip select high |
| cfg_cs_hold | input | 1 | Keep chip select low across queued words |
| cfg_five_pin | input | 1 | Enable the slave-ready handshake |
| tx_valid | input | 1 | Host offers a word |
| tx_ready | output | 1 | Word is accepted when both are high |
| tx_data | input | DATA_W | Word to send |
| rx_valid | output | 1 | One-cycle done pulse |
| rx_data | output | DATA_W | Received word |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Master data out |
| spi_miso | input | 1 | Master data in |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_rdy_n | input | 1 | Active-low slave ready (asynchronous) |

## Verification
Each of the four clock modes is run with directed words such as 0xA5, 0x5A, 0x80 and 0x01, and also with random words. These runs separate a wrong sampling edge, a wrong bit order and an off-by-one shift. Random divisors and delays, including zero and the maximum of the 5-bit fields, separate the setup, period and trailing counts from each other, because each is checked on its own to the exact cycle. Directed five-pin sequences hold the ready line inactive, and then withhold the inactive-to-active toggle after a word, to show that clocking waits for the right condition. A back-to-back pair under hold separates held framing from an ordinary close-and-reopen.

// File: rtl/spi_hs_pkg.sv
package spi_hs_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SETUP = 2'd1,
      ST_SHIFT = 2'd2,
      ST_TRAIL = 2'd3
   } spi_hs_state_e;

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/spi_hs_sync.sv
module spi_hs_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("spi_hs_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= RST_VAL;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= RST_VAL;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/spi_hs_clkgen.sv
module spi_hs_clkgen #(
   parameter int DATA_W = 8,
   parameter int HALF_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              cpol,
   input  logic [HALF_W-1:0] half_eff,
   output logic              sclk,
   output logic              tick,
   output logic              lead,
   output logic              last
);

   localparam int NEDGE  = 2 * DATA_W;
   localparam int EDGE_W = $clog2(NEDGE);

   if (HALF_W < 1) begin : g_bad_half
      $error("spi_hs_clkgen: HALF_W must be at least 1");
   end

   logic [HALF_W-1:0] hcnt;
   logic [EDGE_W-1:0] idx;
   logic              primed;

   assign tick = run & (hcnt == '0);
   assign lead = tick & ~idx[0];
   assign last = tick & (idx == EDGE_W'(NEDGE - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hcnt   <= '0;
         idx    <= '0;
         sclk   <= 1'b0;
         primed <= 1'b0;
      end else begin
         primed <= 1'b1;
         if (!run) begin
            hcnt <= half_eff - HALF_W'(1);
            idx  <= '0;
            sclk <= cpol;
         end else if (hcnt == '0) begin
            hcnt <= half_eff - HALF_W'(1);
            idx  <= idx + EDGE_W'(1);
            sclk <= ~sclk;
         end else begin
            hcnt <= hcnt - HALF_W'(1);
         end
      end
   end

   // R1: outside a shift phase the clock settles to the polarity level
   assert_idle_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && !run && $past(!run) && $stable(cpol)) |-> (sclk == cpol));

endmodule

// File: rtl/spi_hs_shift.sv
module spi_hs_shift #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_word,
   input  logic              cpha,
   input  logic              tick,
   input  logic              lead,
   input  logic              last,
   input  logic              miso,
   output logic              mosi,
   output logic [DATA_W-1:0] rx_word
);

   if (DATA_W < 2) begin : g_bad_width
      $error("spi_hs_shift: DATA_W must be at least 2");
   end

   logic [DATA_W-1:0] tx_sh;
   logic [DATA_W-1:0] rx_sh;
   logic              mosi_q;
   logic              sample;
   logic              drive;

   assign sample  = tick & (cpha ? ~lead : lead);
   assign drive   = tick & (cpha ? lead : (~lead & ~last));
   assign rx_word = sample ? {rx_sh[DATA_W-2:0], miso} : rx_sh;
   assign mosi    = mosi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh  <= '0;
         rx_sh  <= '0;
         mosi_q <= 1'b0;
      end else if (load) begin
         rx_sh <= '0;
         if (cpha) begin
            tx_sh <= load_word;
         end else begin
            tx_sh  <= load_word << 1;
            mosi_q <= load_word[DATA_W-1];
         end
      end else begin
         if (sample) rx_sh <= rx_word;
         if (drive) begin
            mosi_q <= tx_sh[DATA_W-1];
            tx_sh  <= tx_sh << 1;
         end
      end
   end

   // R2: the output bit only moves on a drive edge or a word load
   assert_mosi_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!drive && !load) |=> $stable(mosi));

endmodule

// File: rtl/spi_hs_master.sv
module spi_hs_master
   import spi_hs_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int HALF_W      = 8,
   parameter int SETUP_W     = 5,
   parameter int TRAIL_W     = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_cpol,
   input  logic               cfg_cpha,
   input  logic [HALF_W-1:0]  cfg_half,
   input  logic [SETUP_W-1:0] cfg_setup,
   input  logic [TRAIL_W-1:0] cfg_trail,
   input  logic               cfg_cs_hold,
   input  logic               cfg_five_pin,
   input  logic               tx_valid,
   output logic               tx_ready,
   input  logic [DATA_W-1:0]  tx_data,
   output logic               rx_valid,
   output logic [DATA_W-1:0]  rx_data,
   output logic               spi_sclk,
   output logic               spi_mosi,
   input  logic               spi_miso,
   output logic               spi_cs_n,
   input  logic               spi_rdy_n
);

   localparam int CNT_W = max_int(SETUP_W, TRAIL_W);

   if (SETUP_W < 1 || TRAIL_W < 1) begin : g_bad_delay
      $error("spi_hs_master: delay fields need at least one bit");
   end

   spi_hs_state_e     state;
   logic [CNT_W-1:0]  cnt;
   logic              cs_n_q;
   logic              rx_valid_q;
   logic [DATA_W-1:0] rx_data_q;
   logic              armed;
   logic              seen_off;
   logic [HALF_W-1:0] half_eff;
   logic              rdy_n_s;
   logic              slave_rdy;
   logic              go_ok;
   logic              run;
   logic              tick;
   logic              lead;
   logic              last;
   logic              load;
   logic              next_word;
   logic [DATA_W-1:0] rx_word;

   assign half_eff  = (cfg_half == '0) ? HALF_W'(1) : cfg_half;
   assign run       = (state == ST_SHIFT);
   assign slave_rdy = ~rdy_n_s;
   assign go_ok     = ~cfg_five_pin | (slave_rdy & (~armed | seen_off));
   assign next_word = cfg_cs_hold & tx_valid;
   assign tx_ready  = (state == ST_IDLE) | (run & last & cfg_cs_hold);
   assign load      = tx_valid & tx_ready;

   spi_hs_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (spi_rdy_n),
      .q     (rdy_n_s)
   );

   spi_hs_clkgen #(
      .DATA_W (DATA_W),
      .HALF_W (HALF_W)
   ) u_clkgen (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .cpol     (cfg_cpol),
      .half_eff (half_eff),
      .sclk     (spi_sclk),
      .tick     (tick),
      .lead     (lead),
      .last     (last)
   );

   spi_hs_shift #(
      .DATA_W (DATA_W)
   ) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_word (tx_data),
      .cpha      (cfg_cpha),
      .tick      (tick),
      .lead      (lead),
      .last      (last),
      .miso      (spi_miso),
      .mosi      (spi_mosi),
      .rx_word   (rx_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         cnt        <= '0;
         cs_n_q     <= 1'b1;
         rx_valid_q <= 1'b0;
         rx_data_q  <= '0;
         armed      <= 1'b0;
         seen_off   <= 1'b0;
      end else begin
         rx_valid_q <= 1'b0;
         if (armed && !slave_rdy) seen_off <= 1'b1;
         case (state)
            ST_IDLE: begin
               if (tx_valid) begin
                  state  <= ST_SETUP;
                  cnt    <= CNT_W'(cfg_setup);
                  cs_n_q <= 1'b0;
               end
            end
            ST_SETUP: begin
               if (cnt != '0) begin
                  cnt <= cnt - CNT_W'(1);
               end else if (go_ok) begin
                  state <= ST_SHIFT;
                  armed <= 1'b0;
               end
            end
            ST_SHIFT: begin
               if (last) begin
                  rx_data_q <= rx_word;
                  armed     <= cfg_five_pin;
                  seen_off  <= 1'b0;
                  if (next_word) begin
                     rx_valid_q <= 1'b1;
                     state      <= ST_SETUP;
                     cnt        <= CNT_W'(cfg_setup);
                  end else begin
                     state <= ST_TRAIL;
                     cnt   <= CNT_W'(cfg_trail);
                  end
               end
            end
            ST_TRAIL: begin
               if (cnt != '0) begin
                  cnt <= cnt - CNT_W'(1);
               end else begin
                  cs_n_q     <= 1'b1;
                  rx_valid_q <= 1'b1;
                  state      <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign spi_cs_n = cs_n_q;
   assign rx_valid = rx_valid_q;
   assign rx_data  = rx_data_q;

   // R6: done is a single-cycle pulse
   assert_rx_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_q |=> !rx_valid_q);

   // R3: every generated clock edge falls inside an open frame
   assert_edge_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((spi_sclk != $past(spi_sclk)) && $past(run)) |-> !cs_n_q);

   // R5: an unheld word ends at the idle level with select still low
   assert_final_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (run && last && !next_word) |=> ((spi_sclk == cfg_cpol) && !cs_n_q));

   // R7: a queued word under hold keeps select low and reports the first word
   assert_hold_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (run && last && next_word) |=> (!cs_n_q && rx_valid_q));

   // R8: an inactive ready line keeps the setup phase from starting clocking
   assert_wait_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_SETUP) && cfg_five_pin && !slave_rdy) |=> (state != ST_SHIFT));

   // R9: no new word clocks before the ready line has toggled off and on
   assert_rearm_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_SETUP) && cfg_five_pin && armed && !seen_off) |=> (state != ST_SHIFT));

endmodule

// File: tb/spi_hs_master_tb_top.sv
module spi_hs_master_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int DW         = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_cpol = 1'b0, cfg_cpha = 1'b0;
   logic [7:0]    cfg_half = 8'd1;
   logic [4:0]    cfg_setup = 5'd0, cfg_trail = 5'd0;
   logic          cfg_cs_hold = 1'b0, cfg_five_pin = 1'b0;
   logic          tx_valid = 1'b0;
   logic          tx_ready;
   logic [DW-1:0] tx_data = '0;
   logic          rx_valid;
   logic [DW-1:0] rx_data;
   logic          spi_sclk, spi_mosi, spi_cs_n;
   logic          spi_miso = 1'b0;
   logic          spi_rdy_n = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_hs_master dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
      .cfg_half(cfg_half), .cfg_setup(cfg_setup), .cfg_trail(cfg_trail),
      .cfg_cs_hold(cfg_cs_hold), .cfg_five_pin(cfg_five_pin),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
      .rx_valid(rx_valid), .rx_data(rx_data), .spi_sclk(spi_sclk),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n),
      .spi_rdy_n(spi_rdy_n)
   );

   int n_checks = 0, n_fail = 0;
   int cyc = 0, cfg_t = 0, rel_t = 0;
   int cs_fall_t = 0, last_edge_t = 0, edge_n = 0;
   int widx = 0, rxcnt = 0, m_cnt = 0, cs_rise_cnt = 0, ena_cnt = 0;
   bit await_first = 0, ena_chk = 0, auto_ena = 0, finished = 0;
   logic prev_cs = 1'b1, prev_sclk = 1'b0, prev_rxv = 1'b0;
   logic [DW-1:0] s_tx = '0, s_rx = '0;
   logic [DW-1:0] m_words [256];
   logic [DW-1:0] s_words [256];

   function automatic int half_eff(input logic [7:0] h);
      return (h == 8'd0) ? 1 : int'(h);
   endfunction

   function automatic int setup_gap(input logic [4:0] sd, input logic [7:0] h);
      return int'(sd) + half_eff(h) + 1;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   endtask

   // slave model and protocol monitor
   always @(negedge clk) begin
      if (!rst_n) begin
         prev_cs   = 1'b1;
         prev_sclk = spi_sclk;
      end else begin
         cyc++;
         if (ena_cnt > 0) begin
            ena_cnt--;
            if (ena_cnt == 0) spi_rdy_n = 1'b0;
         end
         if (prev_cs && !spi_cs_n) begin
            check(prev_sclk == cfg_cpol, "R1 idle clock level", int'(prev_sclk), int'(cfg_cpol));
            cs_fall_t   = cyc;
            await_first = 1;
            edge_n      = 0;
            s_rx        = '0;
            s_tx        = s_words[widx];
            if (!cfg_cpha) begin
               spi_miso = s_tx[DW-1];
               s_tx     = s_tx << 1;
            end
         end
         if (spi_sclk !== prev_sclk) begin
            if (spi_cs_n) begin
               if (cyc - cfg_t > 2) check(0, "R3 edge outside frame", 1, 0);
            end else begin
               bit lead;
               edge_n++;
               lead = (edge_n % 2) == 1;
               if (await_first) begin
                  if (!cfg_five_pin)
                     check(cyc - cs_fall_t == setup_gap(cfg_setup, cfg_half), "R4 setup gap",
                           cyc - cs_fall_t, setup_gap(cfg_setup, cfg_half));
                  if (ena_chk) begin
                     check(cyc - rel_t == half_eff(cfg_half) + 3, "R8 ready release to first edge",
                           cyc - rel_t, half_eff(cfg_half) + 3);
                     ena_chk = 0;
                  end
                  await_first = 0;
               end else if (edge_n != 1) begin
                  check(cyc - last_edge_t == half_eff(cfg_half), "R3 edge spacing",
                        cyc - last_edge_t, half_eff(cfg_half));
               end
               last_edge_t = cyc;
               if (lead ^ cfg_cpha) s_rx = {s_rx[DW-2:0], spi_mosi};
               if (cfg_cpha ? lead : (!lead && edge_n != 16)) begin
                  spi_miso = s_tx[DW-1];
                  s_tx     = s_tx << 1;
               end
               if (edge_n == 16) begin
                  check(s_rx == m_words[widx], "R2 word at slave", int'(s_rx), int'(m_words[widx]));
                  check(spi_sclk == cfg_cpol, "R5 final edge level", int'(spi_sclk), int'(cfg_cpol));
                  widx++;
                  edge_n = 0;
                  s_rx   = '0;
                  s_tx   = s_words[widx];
                  if (!cfg_cpha) begin
                     spi_miso = s_tx[DW-1];
                     s_tx     = s_tx << 1;
                  end
                  if (auto_ena && cfg_five_pin) begin
                     spi_rdy_n = 1'b1;
                     ena_cnt   = 3;
                  end
               end
            end
         end
         if (!prev_cs && spi_cs_n) begin
            cs_rise_cnt++;
            check(cyc - last_edge_t == int'(cfg_trail) + 1, "R5 trailing gap",
                  cyc - last_edge_t, int'(cfg_trail) + 1);
            check(rx_valid == 1'b1, "R6 done with select rise", int'(rx_valid), 1);
            check(edge_n == 0, "R3 edges per word", edge_n, 0);
         end
         if (rx_valid) begin
            check(!prev_rxv, "R6 single pulse", int'(prev_rxv), 0);
            check(rx_data == s_words[rxcnt], "R2 received word", int'(rx_data), int'(s_words[rxcnt]));
            rxcnt++;
         end
         prev_rxv  = rx_valid;
         prev_cs   = spi_cs_n;
         prev_sclk = spi_sclk;
      end
   end

   task automatic set_cfg(input logic cp, input logic ch, input logic [7:0] h,
                          input logic [4:0] sd, input logic [4:0] td,
                          input logic hold, input logic five);
      cfg_cpol = cp; cfg_cpha = ch; cfg_half = h; cfg_setup = sd;
      cfg_trail = td; cfg_cs_hold = hold; cfg_five_pin = five;
      cfg_t = cyc;
      repeat (3) begin @(negedge clk); #1; end
   endtask

   task automatic send(input logic [DW-1:0] d, input bit keep);
      m_words[m_cnt] = d;
      m_cnt++;
      tx_data  = d;
      tx_valid = 1'b1;
      while (!tx_ready) begin @(negedge clk); #1; end
      @(negedge clk); #1;
      if (!keep) tx_valid = 1'b0;
   endtask

   task automatic wait_rx(input int n);
      while (rxcnt < n) begin @(negedge clk); #1; end
      repeat (2) begin @(negedge clk); #1; end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", rxcnt, m_cnt);
      summary();
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      for (int i = 0; i < 256; i++) s_words[i] = DW'($urandom);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      // R1: reset state
      check(spi_cs_n == 1'b1, "R1 reset select", int'(spi_cs_n), 1);
      check(rx_valid == 1'b0, "R1 reset done", int'(rx_valid), 0);
      check(tx_ready == 1'b1, "R1 reset ready", int'(tx_ready), 1);
      check(spi_sclk == 1'b0, "R1 reset clock level", int'(spi_sclk), 0);

      // R2: each clock mode with directed words
      for (int m = 0; m < 4; m++) begin
         set_cfg(logic'(m >> 1), logic'(m & 1), 8'd2, 5'd1, 5'd2, 1'b0, 1'b0);
         send(8'hA5, 0); wait_rx(m_cnt);
         send(8'h5A, 0); wait_rx(m_cnt);
         send(8'h80, 0); wait_rx(m_cnt);
         send(8'h01, 0); wait_rx(m_cnt);
      end

      // R3, R4, R5: extreme delays and the zero divisor
      set_cfg(1'b0, 1'b1, 8'd0, 5'd31, 5'd31, 1'b0, 1'b0);
      send(8'hC3, 0); wait_rx(m_cnt);
      set_cfg(1'b1, 1'b0, 8'd5, 5'd0, 5'd0, 1'b0, 1'b0);
      send(8'h3C, 0); wait_rx(m_cnt);

      // R7: back-to-back pair under hold
      begin
         int rises;
         set_cfg(1'b1, 1'b1, 8'd2, 5'd2, 5'd3, 1'b1, 1'b0);
         rises = cs_rise_cnt;
         send(8'h96, 1);
         send(8'h69, 0);
         wait_rx(m_cnt);
         check(cs_rise_cnt - rises == 1, "R7 select held across pair", cs_rise_cnt - rises, 1);
      end

      // random mix
      for (int i = 0; i < 30; i++) begin
         set_cfg(logic'($urandom_range(0, 1)), logic'($urandom_range(0, 1)),
                 8'($urandom_range(0, 4)), 5'($urandom_range(0, 9)),
                 5'($urandom_range(0, 9)), logic'($urandom_range(0, 1)), 1'b0);
         send(DW'($urandom), 0);
         wait_rx(m_cnt);
      end

      // R10: ready line inactive but handshake off
      spi_rdy_n = 1'b1;
      set_cfg(1'b0, 1'b0, 8'd1, 5'd3, 5'd1, 1'b0, 1'b0);
      send(8'hE7, 0); wait_rx(m_cnt);

      // R8: ready line released late
      set_cfg(1'b0, 1'b1, 8'd2, 5'd2, 5'd1, 1'b0, 1'b1);
      send(8'h7E, 0);
      while (spi_cs_n) begin @(negedge clk); #1; end
      repeat (10) begin @(negedge clk); #1; end
      check(edge_n == 0, "R8 no clocking while not ready", edge_n, 0);
      rel_t     = cyc;
      ena_chk   = 1;
      spi_rdy_n = 1'b0;
      wait_rx(m_cnt);

      // R9: no toggle after the word, so the next one must wait
      send(8'hB4, 0);
      while (spi_cs_n) begin @(negedge clk); #1; end
      repeat (40) begin @(negedge clk); #1; end
      check(edge_n == 0 && !spi_cs_n, "R9 waits for ready toggle", edge_n, 0);
      check(spi_sclk == cfg_cpol, "R9 clock idle while waiting", int'(spi_sclk), int'(cfg_cpol));
      spi_rdy_n = 1'b1;
      repeat (4) begin @(negedge clk); #1; end
      spi_rdy_n = 1'b0;
      wait_rx(m_cnt);
      spi_rdy_n = 1'b1;
      repeat (4) begin @(negedge clk); #1; end
      spi_rdy_n = 1'b0;

      // five-pin stream with the slave toggling ready after each word
      auto_ena = 1;
      for (int i = 0; i < 6; i++) begin
         set_cfg(logic'($urandom_range(0, 1)), logic'($urandom_range(0, 1)),
                 8'($urandom_range(1, 3)), 5'($urandom_range(0, 4)),
                 5'($urandom_range(0, 4)), 1'b0, 1'b1);
         send(DW'($urandom), 0);
         wait_rx(m_cnt);
         repeat (5) begin @(negedge clk); #1; end
      end

      check(rxcnt == m_cnt, "R6 done count", rxcnt, m_cnt);
      summary();
   end

endmodule